// File: doc/BRIEF.md
# Dual-Word Numerically Controlled Oscillator with Quadrant Phase Select

This block is a sine-wave numerically controlled oscillator. On every clock it forms a phase increment from two 48-bit frequency words. The first word always contributes. The second word can be switched in or out by a single input. The increment is added into a 48-bit phase accumulator. A quadrant offset of 0, 90, 180 or 270 degrees, picked by two select inputs, is added to the top of the phase. The result drives a quarter-wave amplitude table with mirror and sign logic. The signed 16-bit amplitude is then rounded to a 14-bit offset-binary sample.

Toggling the enable of the second word gives binary frequency-shift keying. The quadrant inputs give coarse phase-shift keying. An accumulator-clear input restarts the phase at zero. Two instances cleared in the same cycle, with quadrant selects one step apart, therefore produce a sine/cosine pair. Every input travels the same pipeline, so any input change reaches the sample output a fixed number of clocks later.

Top module: `dualword_nco`

## Requirements
- R1: On each accepted clock edge the increment is (center + gated offset) mod 2^48. This sum is added modulo 2^48 into the accumulator, so a center of 0x4000_0000_0000 plus an offset of 0xC000_0000_0000 gives a zero increment and a constant phase. Accumulator bit 47 carries a weight of 180 degrees, and the phase wraps to zero after full scale.
- R2: When `offset_en` is 0 the offset word contributes zero to the increment. When `offset_en` is 1 the offset word is added in full.
- R3: `quad_sel` (a 2-bit unsigned number q) adds q × 90 degrees of phase. That is, q is added modulo 4 to accumulator bits 47:46 before the amplitude lookup.
- R4: The amplitude is indexed by the upper 10 bits of the offset phase. Bits 9:8 of this index are the quadrant and bits 7:0 are k. The table holds T(k) = round(32767·sin(2π(k+0.5)/1024)). Each quadrant gives a signed amplitude as follows:
  - quadrant 0: +T(k)
  - quadrant 1: +T(255−k)
  - quadrant 2: −T(k)
  - quadrant 3: −T(255−k)
- R5: The 16-bit amplitude a is rounded as r = floor((a+2)/4). The result saturates at 8191. The sample is (r + 8192) mod 2^14, in offset binary. The largest positive amplitude gives 0x3FFF and the most negative gives 0x0000.
- R6: When `acc_clear` is 1 at an edge, the accumulator becomes zero instead of accumulating. The sample produced for that edge therefore depends only on `quad_sel`.
- R7: Inputs present at a rising edge first determine `sample` after the 14th rising edge, counting that edge as the first.
- R8: Reset is synchronous and active high. From the first edge in reset, and for 13 edges after release, `sample` is mid-scale 0x2000. Reset also zeroes the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| center_word | input | 48 | Center frequency word, always added |
| offset_word | input | 48 | Offset frequency word, gated by `offset_en` |
| offset_en | input | 1 | 1 adds the offset word, 0 zeroes it |
| quad_sel | input | 2 | Quadrant phase offset, q × 90 degrees |
| acc_clear | input | 1 | 1 loads zero into the phase accumulator |
| sample | output | 14 | Offset-binary sine sample |

## Verification
The accumulator clear and a change of `offset_en` or `quad_sel` can land on the same clock edge. The clear decides the accumulator value for that edge. The gating and the quadrant decide the increment that follows and the phase offset applied to the zeroed phase. The bench provokes this overlap repeatedly in a directed loop, and also through occasional clears inside the random run. A bench model takes each edge's inputs together and predicts the sample exactly 14 edges later. The same model judges the saturating quadrant codes and the two's-complement cancellation of the two words.

// File: rtl/dwnco_pkg.sv
package dwnco_pkg;
   localparam int FREQ_W_DEF    = 48;
   localparam int AMP_W_DEF     = 16;
   localparam int OUT_W_DEF     = 14;
   localparam int QTR_ABITS_DEF = 8;
   localparam int LATENCY_DEF   = 14;
   // registered stages before the output delay line: step, accumulate,
   // phase offset, table read, rounding
   localparam int CORE_STAGES   = 5;
   localparam real TWO_PI       = 6.28318530717958;

   typedef enum logic [1:0] {QUAD_0, QUAD_90, QUAD_180, QUAD_270} quad_e;
endpackage

// File: rtl/dwnco_step.sv
// Stage 1: gated sum of the two frequency words, with the side inputs
// registered alongside so that every input enters the pipe at one edge.
module dwnco_step #(
   parameter int FREQ_W = 48
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] center_i,
   input  logic [FREQ_W-1:0] offset_i,
   input  logic              ofs_en_i,
   input  logic [1:0]        quad_i,
   input  logic              clr_i,
   output logic [FREQ_W-1:0] inc_q,
   output logic [1:0]        quad_q,
   output logic              clr_q,
   output logic              vld_q
);
   logic [FREQ_W-1:0] ofs_gated;

   always_comb ofs_gated = ofs_en_i ? offset_i : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         inc_q  <= '0;
         quad_q <= '0;
         clr_q  <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         inc_q  <= center_i + ofs_gated;
         quad_q <= quad_i;
         clr_q  <= clr_i;
         vld_q  <= 1'b1;
      end
   end

   // R2: a disabled offset leaves the center word alone as the increment
   assert_offset_gate_R2: assert property (@(posedge clk) disable iff (rst)
      !ofs_en_i |=> inc_q == $past(center_i));
endmodule

// File: rtl/dwnco_accum.sv
// Stages 2 and 3: phase accumulator with clear, then quadrant offset
// added to the lookup-index bits of the phase.
module dwnco_accum #(
   parameter int FREQ_W = 48,
   parameter int IDX_W  = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] inc_i,
   input  logic [1:0]        quad_i,
   input  logic              clr_i,
   input  logic              vld_i,
   output logic [IDX_W-1:0]  ph_q,
   output logic              vld_q
);
   logic [FREQ_W-1:0] acc_q;
   logic [1:0]        quad_d;
   logic              vld_d;
   logic [IDX_W-1:0]  quad_term;

   always_comb quad_term = {quad_d, {(IDX_W-2){1'b0}}};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         quad_d <= '0;
         vld_d  <= 1'b0;
      end else begin
         acc_q  <= clr_i ? '0 : acc_q + inc_i;
         quad_d <= quad_i;
         vld_d  <= vld_i;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q  <= '0;
         vld_q <= 1'b0;
      end else begin
         ph_q  <= acc_q[FREQ_W-1 -: IDX_W] + quad_term;
         vld_q <= vld_d;
      end
   end

   // R6: a clear leaves a zero phase in the accumulator
   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
      clr_i |=> acc_q == '0);
endmodule

// File: rtl/dwnco_sine.sv
// Stage 4: quarter-wave table with mirror and sign logic per quadrant.
module dwnco_sine
   import dwnco_pkg::*;
#(
   parameter int QTR_ABITS = 8,
   parameter int AMP_W     = 16,
   localparam int IDX_W    = QTR_ABITS + 2,
   localparam int QN       = 1 << QTR_ABITS,
   localparam int MAG_W    = AMP_W - 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [IDX_W-1:0]        ph_i,
   input  logic                    vld_i,
   output logic signed [AMP_W-1:0] amp_q,
   output logic                    vld_q
);
   localparam real FULL = real'((2 ** MAG_W) - 1);

   logic [MAG_W-1:0]     qtab [QN];
   quad_e                quad;
   logic [QTR_ABITS-1:0] k_raw;
   logic [QTR_ABITS-1:0] k_eff;
   logic [MAG_W-1:0]     mag;
   logic signed [AMP_W-1:0] mag_s;

   for (genvar i = 0; i < QN; i++) begin : g_tab
      assign qtab[i] = MAG_W'($rtoi(FULL * $sin(TWO_PI * (real'(i) + 0.5) / real'(4 * QN)) + 0.5));
   end

   always_comb begin
      quad  = quad_e'(ph_i[IDX_W-1 -: 2]);
      k_raw = ph_i[QTR_ABITS-1:0];
      k_eff = (quad == QUAD_90 || quad == QUAD_270) ? ~k_raw : k_raw;
      mag   = qtab[k_eff];
      mag_s = {1'b0, mag};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_q <= '0;
         vld_q <= 1'b0;
      end else begin
         amp_q <= (quad == QUAD_180 || quad == QUAD_270) ? -mag_s : mag_s;
         vld_q <= vld_i;
      end
   end

   // R4: the sign of the amplitude follows the half-turn phase bit
   assert_sign_half_R4: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> amp_q[AMP_W-1] == $past(ph_i[IDX_W-1]));
endmodule

// File: rtl/dwnco_quant.sv
// Stage 5 and the output delay line: round to OUT_W with saturation,
// convert to offset binary, then pad the pipe to the chosen latency.
module dwnco_quant #(
   parameter int AMP_W = 16,
   parameter int OUT_W = 14,
   parameter int PAD   = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic signed [AMP_W-1:0] amp_i,
   input  logic                    vld_i,
   output logic [OUT_W-1:0]        sample_o
);
   localparam int SH = AMP_W - OUT_W;
   localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);
   localparam logic signed [AMP_W:0] MAXO = (AMP_W+1)'((2 ** (OUT_W - 1)) - 1);

   logic signed [OUT_W-1:0] rnd;
   logic [OUT_W-1:0]        code;
   logic [OUT_W-1:0]        q0;

   if (SH == 0) begin : g_pass
      always_comb rnd = amp_i;
   end else begin : g_round
      logic signed [AMP_W:0] ext;
      logic signed [AMP_W:0] shr;
      always_comb begin
         ext = {amp_i[AMP_W-1], amp_i} + (AMP_W+1)'(2 ** (SH - 1));
         shr = ext >>> SH;
         rnd = (shr > MAXO) ? MAXO[OUT_W-1:0] : shr[OUT_W-1:0];
      end
   end

   always_comb code = {~rnd[OUT_W-1], rnd[OUT_W-2:0]};

   always_ff @(posedge clk) begin
      if (rst) q0 <= MID;
      else     q0 <= vld_i ? code : MID;
   end

   if (PAD == 0) begin : g_nopad
      assign sample_o = q0;
   end else begin : g_pad
      logic [OUT_W-1:0] dly [PAD];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int j = 0; j < PAD; j++) dly[j] <= MID;
         end else begin
            dly[0] <= q0;
            for (int j = 1; j < PAD; j++) dly[j] <= dly[j-1];
         end
      end
      assign sample_o = dly[PAD-1];
   end

   // R5: the largest positive amplitude saturates to the top code
   assert_round_sat_R5: assert property (@(posedge clk) disable iff (rst)
      (vld_i && amp_i == AMP_W'((2 ** (AMP_W - 1)) - 1)) |=> q0 == {OUT_W{1'b1}});
endmodule

// File: rtl/dualword_nco.sv
module dualword_nco
   import dwnco_pkg::*;
#(
   parameter int FREQ_W    = FREQ_W_DEF,
   parameter int QTR_ABITS = QTR_ABITS_DEF,
   parameter int AMP_W     = AMP_W_DEF,
   parameter int OUT_W     = OUT_W_DEF,
   parameter int LATENCY   = LATENCY_DEF
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [FREQ_W-1:0] center_word,
   input  logic [FREQ_W-1:0] offset_word,
   input  logic              offset_en,
   input  logic [1:0]        quad_sel,
   input  logic              acc_clear,
   output logic [OUT_W-1:0]  sample
);
   localparam int IDX_W = QTR_ABITS + 2;
   localparam int PAD   = LATENCY - CORE_STAGES;
   localparam logic [OUT_W-1:0] MID = OUT_W'(1) << (OUT_W - 1);

   if (LATENCY < CORE_STAGES) begin : g_chk_lat
      $error("LATENCY below the number of core stages");
   end
   if (OUT_W > AMP_W || OUT_W < 2) begin : g_chk_out
      $error("OUT_W must lie between 2 and AMP_W");
   end
   if (IDX_W > FREQ_W || QTR_ABITS < 2) begin : g_chk_idx
      $error("table index does not fit the accumulator");
   end

   logic [FREQ_W-1:0]       inc;
   logic [1:0]              quad_r;
   logic                    clr_r;
   logic                    vld1, vld3, vld4;
   logic [IDX_W-1:0]        ph;
   logic signed [AMP_W-1:0] amp;

   dwnco_step #(.FREQ_W(FREQ_W)) u_step (
      .clk(clk), .rst(rst), .center_i(center_word), .offset_i(offset_word),
      .ofs_en_i(offset_en), .quad_i(quad_sel), .clr_i(acc_clear),
      .inc_q(inc), .quad_q(quad_r), .clr_q(clr_r), .vld_q(vld1));

   dwnco_accum #(.FREQ_W(FREQ_W), .IDX_W(IDX_W)) u_accum (
      .clk(clk), .rst(rst), .inc_i(inc), .quad_i(quad_r), .clr_i(clr_r),
      .vld_i(vld1), .ph_q(ph), .vld_q(vld3));

   dwnco_sine #(.QTR_ABITS(QTR_ABITS), .AMP_W(AMP_W)) u_sine (
      .clk(clk), .rst(rst), .ph_i(ph), .vld_i(vld3), .amp_q(amp), .vld_q(vld4));

   dwnco_quant #(.AMP_W(AMP_W), .OUT_W(OUT_W), .PAD(PAD)) u_quant (
      .clk(clk), .rst(rst), .amp_i(amp), .vld_i(vld4), .sample_o(sample));

   // R8: the first edge out of reset still shows mid-scale
   assert_reset_mid_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> sample == MID);
endmodule

// File: tb/dualword_nco_test.sv
module dualword_nco_test;
   localparam int LAT = 14;
   localparam logic [13:0] MID = 14'h2000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [47:0] center_word = '0;
   logic [47:0] offset_word = '0;
   logic        offset_en = 1'b0;
   logic [1:0]  quad_sel = '0;
   logic        acc_clear = 1'b0;
   logic [13:0] sample;

   always #5 clk = ~clk;

   dualword_nco uut (
      .clk(clk), .rst(rst), .center_word(center_word), .offset_word(offset_word),
      .offset_en(offset_en), .quad_sel(quad_sel), .acc_clear(acc_clear),
      .sample(sample));

   int          n_chk = 0;
   int          n_fail = 0;
   logic [47:0] m_acc = '0;
   logic [13:0] exp_q[$];
   string       tag_q[$];

   function automatic logic [13:0] ref_sample(logic [47:0] p, logic [1:0] q);
      logic [9:0] idx;
      logic [7:0] k;
      int t, v, r;
      real a;
      idx = p[47:38] + {q, 8'd0};
      k   = idx[8] ? 8'd255 - idx[7:0] : idx[7:0];
      a   = 32767.0 * $sin(6.28318530717958 * (real'(k) + 0.5) / 1024.0);
      t   = $rtoi(a + 0.5);
      v   = idx[9] ? -t : t;
      r   = (v + 2) >>> 2;
      if (r > 8191) r = 8191;
      return 14'(r + 8192);
   endfunction

   task automatic check(string tag, logic [13:0] act, logic [13:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s: sample=%h expected=%h at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic cyc(string tag);
      logic [47:0] inc;
      @(posedge clk);
      if (rst) begin
         m_acc = '0;
      end else begin
         inc   = center_word + (offset_en ? offset_word : 48'd0);
         m_acc = acc_clear ? 48'd0 : m_acc + inc;
         exp_q.push_back(ref_sample(m_acc, quad_sel));
         tag_q.push_back(tag);
      end
      @(negedge clk);
      if (rst) begin
         check(tag, sample, MID);
      end else begin
         check(tag_q[0], sample, exp_q[0]);
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   endtask

   task automatic release_reset();
      exp_q.delete();
      tag_q.delete();
      for (int i = 0; i < LAT - 1; i++) begin
         exp_q.push_back(MID);
         tag_q.push_back("R8");
      end
      m_acc = '0;
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      @(negedge clk);
      // reset state
      repeat (3) cyc("R8");
      release_reset();
      repeat (16) cyc("R8");

      // quadrant offsets from a cleared phase
      acc_clear = 1'b1;
      for (int q = 0; q < 4; q++) begin
         quad_sel = 2'(q);
         repeat (16) cyc("R3");
      end
      quad_sel = 2'd1;
      repeat (16) cyc("R5");
      check("R5", sample, 14'h3FFF);
      quad_sel = 2'd3;
      repeat (16) cyc("R5");
      check("R5", sample, 14'h0000);

      // latency: switch the quadrant and watch the exact edge
      quad_sel = 2'd1;
      repeat (16) cyc("R7");
      quad_sel = 2'd3;
      repeat (LAT - 1) cyc("R7");
      check("R7", sample, 14'h3FFF);
      cyc("R7");
      check("R7", sample, 14'h0000);

      // two's-complement cancellation
      quad_sel = 2'd0;
      cyc("R6");
      acc_clear = 1'b0;
      center_word = 48'h4000_0000_0000;
      offset_word = 48'hC000_0000_0000;
      offset_en = 1'b1;
      repeat (24) cyc("R1");
      check("R1", sample, ref_sample(48'd0, 2'd0));

      // wrap-around with one sixteenth of a turn per clock
      offset_en = 1'b0;
      center_word = 48'h1000_0000_0000;
      repeat (48) cyc("R1");

      // offset gating toggles
      center_word = 48'h0040_0000_0000;
      offset_word = 48'h0800_0000_0000;
      for (int i = 0; i < 12; i++) begin
         offset_en = ~offset_en;
         repeat (5) cyc("R2");
      end

      // clear together with offset-enable and quadrant changes
      for (int i = 0; i < 8; i++) begin
         acc_clear = 1'b1;
         offset_en = ~offset_en;
         quad_sel  = quad_sel + 2'd1;
         cyc("R6");
         acc_clear = 1'b0;
         repeat (6) cyc("R6");
      end

      // random stimulus
      for (int i = 0; i < 3000; i++) begin
         if (i % 40 == 0) begin
            center_word = 48'({$urandom(), $urandom()});
            offset_word = ($urandom() % 2 == 0) ? 48'({$urandom(), $urandom()})
                                                : 48'(0) - center_word;
         end
         offset_en = 1'($urandom());
         quad_sel  = 2'($urandom());
         acc_clear = ($urandom() % 50 == 0);
         cyc("R4");
      end

      // reset in the middle of a run
      acc_clear = 1'b0;
      rst = 1'b1;
      repeat (2) cyc("R8");
      release_reset();
      repeat (16) cyc("R8");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule